// File: doc/BRIEF.md
# Dual-Rank Bus Register with Serial Shifter

The block holds two registers of equal width. Rank A faces a shared data bus. Rank B is a serial shift register. On each rising clock edge, a set of active-low controls decides what happens. Rank A can capture the bus, or rank A can take a parallel copy of rank B. Rank B can take a parallel copy of rank A, or rank B can shift by one place. When both copy paths are active on the same edge, the two ranks swap contents.

The bidirectional pins are split into three signals: `bus_in`, `bus_out` and `bus_oe`. `bus_out` always carries rank A. `bus_oe` tells the pad when to drive it. The input disable has priority over the output disable, so the block never drives the pins while it is capturing them.

Rank B shifts toward its top bit. The serial input enters at bit 0, and the serial output is the top bit. Devices can therefore be chained serially to form a longer word. Every control acts on every edge and the block never stalls, so the interface has no valid/ready handshake and no back-pressure. A producer that needs flow control must hold the controls inactive.

Top module: `dual_rank_shifter`

## Requirements
- R1: While `rst_n` is low, both ranks are cleared to all zeros. After reset, `bus_out` is 0, `ser_out` is 0, and rank B reads back as 0.
- R2: At a rising edge with `in_dis_n` low, rank A takes the value of `bus_in`.
- R3: At a rising edge with `down_dis_n` low, rank B takes the value rank A held before that edge.
- R4: At a rising edge with `up_dis_n` low and `in_dis_n` high, rank A takes the value rank B held before that edge.
- R5: At a rising edge with both `up_dis_n` and `down_dis_n` low and `in_dis_n` high, the two ranks exchange their contents.
- R6: At a rising edge with `shift_dis_n` low and `down_dis_n` high, rank B moves one place toward bit W-1 and `ser_in` enters bit 0. `ser_out` always equals bit W-1 of rank B.
- R7: When `in_dis_n`, `up_dis_n`, `down_dis_n` and `shift_dis_n` are all high, both ranks hold their values and `bus_in` is ignored.
- R8: `bus_oe` is 1 only when `out_dis_n` is low and `in_dis_n` is high. `bus_out` carries rank A at all times.
- R9: Bus capture has priority over transfer up on rank A. Transfer down has priority over shift on rank B.
- R10: With `out_dis_n` high (outputs off), load, transfer, swap and shift still work as described in R2 to R6.
- R11: At an edge with both `in_dis_n` and `down_dis_n` low, rank A takes `bus_in` and rank B takes rank A's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both ranks update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | W | Value present on the shared bus pins |
| bus_out | output | W | Data for the bus drivers (rank A) |
| bus_oe | output | 1 | Bus driver enable, active high |
| out_dis_n | input | 1 | Output disable, active low enables driving |
| in_dis_n | input | 1 | Input disable, active low captures the bus into A |
| up_dis_n | input | 1 | Transfer-up disable, active low copies B into A |
| down_dis_n | input | 1 | Transfer-down disable, active low copies A into B |
| shift_dis_n | input | 1 | Shift disable, active low shifts B |
| ser_in | input | 1 | Serial data entering bit 0 of rank B |
| ser_out | output | 1 | Top bit of rank B |

## Verification
The bench targets the following corner cases:

- **Swap edge.** A design that uses an updated value for one of the copies would leave both ranks equal instead of exchanged.
- **Load combined with transfer down.** If rank B received the new bus value instead of A's old value, the check catches it.
- **Priority pairs.** Reversing the priority would put B's data on A, or a shifted value on B.
- **Output enable under input dominance.** An enable that ignores the input disable would drive the pins during a capture.
- **Shifting with outputs off.** A design that gates operations on the output disable would freeze the ranks.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    A_HOLD = 2'd0,
    A_BUS  = 2'd1,
    A_UP   = 2'd2
  } a_sel_t;

  typedef enum logic [1:0] {
    B_HOLD  = 2'd0,
    B_DOWN  = 2'd1,
    B_SHIFT = 2'd2
  } b_sel_t;
endpackage

// File: rtl/dr_ctrl_decode.sv
module dr_ctrl_decode
  import dr_pkg::*;
(
  input  logic   out_dis_n,
  input  logic   in_dis_n,
  input  logic   up_dis_n,
  input  logic   down_dis_n,
  input  logic   shift_dis_n,
  output a_sel_t a_sel,
  output b_sel_t b_sel,
  output logic   drive_en
);
  // rank A: bus capture wins over transfer up
  always_comb begin
    if (!in_dis_n)      a_sel = A_BUS;
    else if (!up_dis_n) a_sel = A_UP;
    else                a_sel = A_HOLD;
  end

  // rank B: transfer down wins over shift
  always_comb begin
    if (!down_dis_n)       b_sel = B_DOWN;
    else if (!shift_dis_n) b_sel = B_SHIFT;
    else                   b_sel = B_HOLD;
  end

  // input disable dominates: never drive while capturing
  assign drive_en = ~out_dis_n & in_dis_n;
endmodule

// File: rtl/dr_rank_a.sv
module dr_rank_a
  import dr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  a_sel_t       sel,
  input  logic [W-1:0] bus_d,
  input  logic [W-1:0] peer_d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else begin
      unique case (sel)
        A_BUS:   q <= bus_d;
        A_UP:    q <= peer_d;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/dr_rank_b.sv
module dr_rank_b
  import dr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  b_sel_t       sel,
  input  logic [W-1:0] peer_d,
  input  logic         ser_in,
  output logic [W-1:0] q,
  output logic         ser_out
);
  logic [W-1:0] shifted;

  generate
    if (W == 1) begin : g_single
      assign shifted = ser_in;
    end else begin : g_multi
      assign shifted = {q[W-2:0], ser_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else begin
      unique case (sel)
        B_DOWN:  q <= peer_d;
        B_SHIFT: q <= shifted;
        default: q <= q;
      endcase
    end
  end

  assign ser_out = q[W-1];
endmodule

// File: rtl/dual_rank_shifter.sv
module dual_rank_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  input  logic         out_dis_n,
  input  logic         in_dis_n,
  input  logic         up_dis_n,
  input  logic         down_dis_n,
  input  logic         shift_dis_n,
  input  logic         ser_in,
  output logic         ser_out
);
  import dr_pkg::*;

  a_sel_t       a_sel;
  b_sel_t       b_sel;
  logic [W-1:0] rank_a_q;
  logic [W-1:0] rank_b_q;

  dr_ctrl_decode u_dec (
    .out_dis_n  (out_dis_n),
    .in_dis_n   (in_dis_n),
    .up_dis_n   (up_dis_n),
    .down_dis_n (down_dis_n),
    .shift_dis_n(shift_dis_n),
    .a_sel      (a_sel),
    .b_sel      (b_sel),
    .drive_en   (bus_oe)
  );

  dr_rank_a #(.W(W)) u_rank_a (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (a_sel),
    .bus_d (bus_in),
    .peer_d(rank_b_q),
    .q     (rank_a_q)
  );

  dr_rank_b #(.W(W)) u_rank_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (b_sel),
    .peer_d (rank_a_q),
    .ser_in (ser_in),
    .q      (rank_b_q),
    .ser_out(ser_out)
  );

  assign bus_out = rank_a_q;
endmodule

// File: rtl/dr_checker.sv
module dr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic         out_dis_n,
  input logic         in_dis_n,
  input logic         up_dis_n,
  input logic         down_dis_n,
  input logic         shift_dis_n,
  input logic         ser_in,
  input logic         ser_out,
  input logic [W-1:0] b_q
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_dis_n |=> bus_out == $past(bus_in));

  p_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !down_dis_n |=> b_q == $past(bus_out));

  p_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dis_n && !up_dis_n) |=> bus_out == $past(b_q));

  p_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dis_n && !up_dis_n && !down_dis_n)
      |=> (bus_out == $past(b_q)) && (b_q == $past(bus_out)));

  p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (down_dis_n && !shift_dis_n)
      |=> (b_q[0] == $past(ser_in)) && (ser_out == $past(b_q[W-2])));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dis_n && up_dis_n && down_dis_n && shift_dis_n)
      |=> $stable(bus_out) && $stable(b_q));

  p_in_dominates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_dis_n |-> !bus_oe);

  p_load_over_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_dis_n && !up_dis_n) |=> bus_out == $past(bus_in));
endmodule

bind dual_rank_shifter dr_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_in     (bus_in),
  .bus_out    (bus_out),
  .bus_oe     (bus_oe),
  .out_dis_n  (out_dis_n),
  .in_dis_n   (in_dis_n),
  .up_dis_n   (up_dis_n),
  .down_dis_n (down_dis_n),
  .shift_dis_n(shift_dis_n),
  .ser_in     (ser_in),
  .ser_out    (ser_out),
  .b_q        (rank_b_q)
);

// File: tb/dual_rank_shifter_tb_top.sv
module dual_rank_shifter_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] bus_out;
  logic         bus_oe;
  logic         out_dis_n = 1'b1, in_dis_n = 1'b1, up_dis_n = 1'b1;
  logic         down_dis_n = 1'b1, shift_dis_n = 1'b1, ser_in = 1'b0;
  logic         ser_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_rank_shifter #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .out_dis_n(out_dis_n), .in_dis_n(in_dis_n),
    .up_dis_n(up_dis_n), .down_dis_n(down_dis_n),
    .shift_dis_n(shift_dis_n), .ser_in(ser_in), .ser_out(ser_out)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive controls at a falling edge, let one rising edge pass, return at next falling edge
  task automatic step(logic in_n, logic up_n, logic dn_n, logic sh_n,
                      logic od_n, logic [W-1:0] d, logic si);
    in_dis_n = in_n; up_dis_n = up_n; down_dis_n = dn_n;
    shift_dis_n = sh_n; out_dis_n = od_n; bus_in = d; ser_in = si;
    @(negedge clk);
    in_dis_n = 1'b1; up_dis_n = 1'b1; down_dis_n = 1'b1;
    shift_dis_n = 1'b1; ser_in = 1'b0;
  endtask

  task automatic load_a(logic [W-1:0] d);
    step(0, 1, 1, 1, 1, d, 0);
  endtask

  // copies B into A via transfer up and returns bus_out
  task automatic read_b(output logic [W-1:0] v);
    step(1, 0, 1, 1, 1, '0, 0);
    v = bus_out;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    check("R1 bus_out after reset", bus_out, '0);
    check("R1 ser_out after reset", {{(W-1){1'b0}}, ser_out}, '0);
    read_b(v);
    check("R1 rank B after reset", v, '0);
  endtask

  task automatic t_load;
    load_a(8'hA5);
    check("R2 load A5", bus_out, 8'hA5);
    load_a(8'h3C);
    check("R2 load 3C", bus_out, 8'h3C);
  endtask

  task automatic t_down_up;
    logic [W-1:0] v;
    load_a(8'h5A);
    step(1, 1, 0, 1, 1, '0, 0);
    load_a(8'h00);
    read_b(v);
    check("R3 transfer down", v, 8'h5A);
    check("R4 transfer up result on bus", bus_out, 8'h5A);
  endtask

  task automatic t_swap;
    logic [W-1:0] v;
    load_a(8'h11);
    step(1, 1, 0, 1, 1, '0, 0);
    load_a(8'h22);
    step(1, 0, 0, 1, 1, '0, 0);
    check("R5 swap A", bus_out, 8'h11);
    read_b(v);
    check("R5 swap B", v, 8'h22);
  endtask

  task automatic t_shift(logic od_n);
    logic [W-1:0] model;
    logic [W-1:0] v;
    logic [15:0] pat;
    load_a(8'h81);
    step(1, 1, 0, 1, od_n, '0, 0);
    model = 8'h81;
    check("R6 ser_out is top bit", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, model[W-1]});
    pat = 16'b1011_0010_1100_1110;
    for (int i = 0; i < 10; i++) begin
      step(1, 1, 1, 0, od_n, '0, pat[i]);
      model = {model[W-2:0], pat[i]};
      check(od_n ? "R10 shift with outputs off" : "R6 serial out",
            {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, model[W-1]});
    end
    read_b(v);
    check("R6 shifted contents", v, model);
  endtask

  task automatic t_hold;
    logic [W-1:0] v;
    load_a(8'hC3);
    step(1, 1, 0, 1, 1, '0, 0);
    load_a(8'h7E);
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 0, 8'(i * 37 + 1), 1);
    check("R7 A holds", bus_out, 8'h7E);
    read_b(v);
    check("R7 B holds", v, 8'hC3);
  endtask

  task automatic t_oe;
    in_dis_n = 1; out_dis_n = 0; #1;
    check("R8 oe driving", {{(W-1){1'b0}}, bus_oe}, 1);
    in_dis_n = 0; out_dis_n = 0; #1;
    check("R8 input dominates", {{(W-1){1'b0}}, bus_oe}, 0);
    in_dis_n = 1; out_dis_n = 1; #1;
    check("R8 output disabled", {{(W-1){1'b0}}, bus_oe}, 0);
    in_dis_n = 0; out_dis_n = 1; #1;
    check("R8 both disabled", {{(W-1){1'b0}}, bus_oe}, 0);
    in_dis_n = 1; out_dis_n = 1;
    @(negedge clk);
  endtask

  task automatic t_prio;
    logic [W-1:0] v;
    load_a(8'h44);
    step(1, 1, 0, 1, 1, '0, 0);
    step(0, 0, 1, 1, 1, 8'h99, 0);
    check("R9 bus load over transfer up", bus_out, 8'h99);
    step(1, 1, 0, 0, 1, '0, 1);
    read_b(v);
    check("R9 transfer down over shift", v, 8'h99);
  endtask

  task automatic t_load_down;
    logic [W-1:0] v;
    load_a(8'h0F);
    step(0, 1, 0, 1, 1, 8'hF0, 0);
    check("R11 A takes bus", bus_out, 8'hF0);
    read_b(v);
    check("R11 B takes old A", v, 8'h0F);
  endtask

  task automatic t_hiz_swap;
    logic [W-1:0] v;
    load_a(8'h12);
    step(1, 1, 0, 1, 1, '0, 0);
    load_a(8'h34);
    step(1, 0, 0, 1, 1, '0, 0);
    check("R10 swap with outputs off A", bus_out, 8'h12);
    check("R10 oe stays low", {{(W-1){1'b0}}, bus_oe}, 0);
    read_b(v);
    check("R10 swap with outputs off B", v, 8'h34);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_down_up();
    t_swap();
    t_shift(1'b0);
    t_shift(1'b1);
    t_hold();
    t_oe();
    t_prio();
    t_load_down();
    t_hiz_swap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule